// File: doc/BRIEF.md
# Video Stream Timing Checker

This block watches the control side of a streaming video bus (a valid strobe plus line-start, line-end, frame-start and frame-end markers) without touching pixel data. It measures every frame it sees: how many valid pixels the closing line carried, how many lines the frame held, the narrowest horizontal blanking gap inside the frame and the vertical blanking, in lines, that came before the frame.

Each measurement is checked against minimums that depend on the kernel size of the processing stage that sits downstream. The minimums can change with the edge-padding setting. The block also compares each frame's dimensions with those of the frame before it and watches for broken marker sequences. Every violation sets a sticky flag that stays set until software-visible logic pulses the clear input. It is meant to sit beside a filter chain as a diagnostic tap.

Top module: `vid_timing_checker`

## Requirements
- R1: A marker counts only in a cycle where `s_valid` is 1. During reset every measurement output is 0 and every error flag is 0.
- R2: `meas_width` reports how many cycles had `s_valid` set from the line-start through the line-end of the last line in the frame, both ends included. Cycles with `s_valid` low inside a line neither count nor close the line. Only a line-end closes it.
- R3: `meas_height` reports how many line-ends fell between the frame-start and the frame-end, both ends included.
- R4: `meas_hblank` reports the smallest line gap within the frame. A line gap is the number of cycles strictly between a line-end and the next line-start. If the frame had no line gap, the output reads all ones.
- R5: `err_hgap` is set when a line gap inside a frame is shorter than a threshold. The threshold is 2 × `kern_w` cycles while `pad_en` is 1, and 12 cycles while `pad_en` is 0.
- R6: The vertical blanking before a frame equals floor(D / P). D is the number of cycles from the previous frame-end to this frame-start. P is the line-start-to-line-start distance of the last line pair measured. P is 0 if no such pair exists yet, and then the blanking is 0. `meas_vblank` shows this value when the frame closes, and shows 0 until a blanking has been measured.
- R7: `err_vgap` is set at a frame-start when the vertical blanking measured for it is below `kern_h`, whatever `pad_en` is. A frame-start with no earlier frame-end is not checked.
- R8: `err_proto` records marker faults, one per bit. Bit 0 is a line-start while a line is open, which covers a repeated start and a missing end. Bit 1 is a line-end with no open line and no line-start in the same cycle. Bit 2 is a frame-start while a frame is open, which covers a repeated start and a missing frame-end. Bit 3 is a frame-end with no open frame and no frame-start in that cycle, or a frame-end without a line-end in the same cycle.
- R9: `err_proto` bit 4 is set when `s_valid` is 1 while no line is open and no line-start is present.
- R10: `err_dim` is set when a frame's width or height differs from the values of the previous frame-end. The first frame-end after reset only stores the reference.
- R11: All four measurement outputs change together, one cycle after a frame-end, and hold at every other time.
- R12: Error flags are sticky. A one-cycle pulse on `clr_err` clears them, but a new violation in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Clears the sticky error flags |
| pad_en | input | 1 | Edge padding in use downstream |
| kern_w | input | KW_W | Kernel width |
| kern_h | input | KW_W | Kernel height |
| s_valid | input | 1 | Pixel valid |
| s_hstart | input | 1 | Line-start marker |
| s_hend | input | 1 | Line-end marker |
| s_vstart | input | 1 | Frame-start marker |
| s_vend | input | 1 | Frame-end marker |
| meas_width | output | DIM_W | Active pixels on the closing line |
| meas_height | output | DIM_W | Active lines in the frame |
| meas_hblank | output | DIM_W | Smallest line gap in the frame |
| meas_vblank | output | DIM_W | Blanking lines before the frame |
| err_hgap | output | 1 | Line gap below minimum |
| err_vgap | output | 1 | Frame gap below minimum |
| err_proto | output | 5 | Marker fault flags |
| err_dim | output | 1 | Frame size changed |

## Verification
The hardest situation to reach is a vertical blanking that lands exactly on a whole number of line periods, one line short of `kern_h` and one line above it. The count depends on the line period measured in the frame before, so the stimulus sizes each idle stretch as the line gap plus a chosen number of full periods. It does this with frames that have holes in `s_valid`, and with frames that have none. Marker faults are reached by hand-written cycle sequences that repeat or drop single markers in the middle of a frame. One clear pulse is placed in the same cycle as a new line-gap violation.

// File: rtl/vid_timing_checker.sv
module vid_timing_checker #(
  parameter int DIM_W = 12,
  parameter int KW_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_err,
  input  logic             pad_en,
  input  logic [KW_W-1:0]  kern_w,
  input  logic [KW_W-1:0]  kern_h,
  input  logic             s_valid,
  input  logic             s_hstart,
  input  logic             s_hend,
  input  logic             s_vstart,
  input  logic             s_vend,
  output logic [DIM_W-1:0] meas_width,
  output logic [DIM_W-1:0] meas_height,
  output logic [DIM_W-1:0] meas_hblank,
  output logic [DIM_W-1:0] meas_vblank,
  output logic             err_hgap,
  output logic             err_vgap,
  output logic [4:0]       err_proto,
  output logic             err_dim
);
  localparam logic [DIM_W-1:0] DMAX = '1;
  localparam logic [KW_W:0]    NOPAD_MIN = (KW_W+1)'(12);

  logic hs_q, he_q, vs_q, ve_q;
  assign hs_q = s_valid & s_hstart;
  assign he_q = s_valid & s_hend;
  assign vs_q = s_valid & s_vstart;
  assign ve_q = s_valid & s_vend;

  logic in_line, in_frame, armed, per_ok, vb_run, ref_ok;
  logic [DIM_W-1:0] pix, last_w, lines, gap, min_gap, per_cnt, period;
  logic [DIM_W-1:0] vb_ph, vb_lines, vb_pend, ref_w, ref_h;

  logic [DIM_W-1:0] pix_n, lines_n, min_base, min_gap_n, ph_inc, vb_inc;
  logic [DIM_W-1:0] vl_final, vb_pend_n, w_now, thr_ext, kh_ext;
  logic [KW_W:0]    thr;
  logic             chk_gap, vb_wrap, hgap_evt, vgap_evt, dim_evt;
  logic [4:0]       proto_evt;

  assign pix_n   = hs_q ? DIM_W'(1) : (in_line & s_valid) ? pix + 1'b1 : pix;
  assign lines_n = (vs_q ? '0 : lines) + {{(DIM_W-1){1'b0}}, he_q};
  assign w_now   = he_q ? pix_n : last_w;

  assign thr     = pad_en ? {kern_w, 1'b0} : NOPAD_MIN;
  assign thr_ext = {{(DIM_W-KW_W-1){1'b0}}, thr};
  assign kh_ext  = {{(DIM_W-KW_W){1'b0}}, kern_h};

  assign chk_gap   = hs_q & armed & ~vs_q;
  assign hgap_evt  = chk_gap & (gap < thr_ext);
  assign min_base  = vs_q ? DMAX : min_gap;
  assign min_gap_n = (chk_gap && gap < min_base) ? gap : min_base;

  assign ph_inc    = vb_ph + 1'b1;
  assign vb_wrap   = vb_run && (period != '0) && (ph_inc == period);
  assign vb_inc    = (vb_lines == DMAX) ? DMAX : vb_lines + 1'b1;
  assign vl_final  = vb_wrap ? vb_inc : vb_lines;
  assign vgap_evt  = vs_q & vb_run & (vl_final < kh_ext);
  assign vb_pend_n = (vs_q & vb_run) ? vl_final : vb_pend;

  assign dim_evt = ve_q & ref_ok & ((w_now != ref_w) | (lines_n != ref_h));

  assign proto_evt[0] = hs_q & in_line;
  assign proto_evt[1] = he_q & ~in_line & ~hs_q;
  assign proto_evt[2] = vs_q & in_frame;
  assign proto_evt[3] = ve_q & ((~in_frame & ~vs_q) | ~he_q);
  assign proto_evt[4] = s_valid & ~in_line & ~hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_line  <= 1'b0;
      in_frame <= 1'b0;
      armed    <= 1'b0;
      per_ok   <= 1'b0;
      vb_run   <= 1'b0;
      ref_ok   <= 1'b0;
      pix      <= '0;
      last_w   <= '0;
      lines    <= '0;
      gap      <= '0;
      min_gap  <= DMAX;
      per_cnt  <= '0;
      period   <= '0;
      vb_ph    <= '0;
      vb_lines <= '0;
      vb_pend  <= '0;
      ref_w    <= '0;
      ref_h    <= '0;
    end else begin
      if (he_q)      in_line <= 1'b0;
      else if (hs_q) in_line <= 1'b1;
      pix   <= pix_n;
      lines <= lines_n;
      if (he_q) last_w <= pix_n;

      if (he_q)               gap <= '0;
      else if (gap != DMAX)   gap <= gap + 1'b1;
      if (he_q)      armed <= 1'b1;
      else if (vs_q) armed <= 1'b0;
      min_gap <= min_gap_n;

      if (hs_q)                   per_cnt <= '0;
      else if (per_cnt != DMAX)   per_cnt <= per_cnt + 1'b1;
      if (hs_q & per_ok & ~vs_q)  period  <= per_cnt + 1'b1;
      if (hs_q)      per_ok <= 1'b1;
      else if (vs_q) per_ok <= 1'b0;

      if (ve_q)      in_frame <= 1'b0;
      else if (vs_q) in_frame <= 1'b1;

      if (ve_q) begin
        vb_run   <= 1'b1;
        vb_ph    <= '0;
        vb_lines <= '0;
      end else if (vs_q) begin
        vb_run   <= 1'b0;
      end else if (vb_run) begin
        vb_ph    <= vb_wrap ? '0 : ph_inc;
        vb_lines <= vl_final;
      end
      vb_pend <= vb_pend_n;

      if (ve_q) begin
        ref_w  <= w_now;
        ref_h  <= lines_n;
        ref_ok <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_width  <= '0;
      meas_height <= '0;
      meas_hblank <= '0;
      meas_vblank <= '0;
      err_hgap    <= 1'b0;
      err_vgap    <= 1'b0;
      err_proto   <= '0;
      err_dim     <= 1'b0;
    end else begin
      if (ve_q) begin
        meas_width  <= w_now;
        meas_height <= lines_n;
        meas_hblank <= min_gap_n;
        meas_vblank <= vb_pend_n;
      end
      err_hgap  <= (err_hgap & ~clr_err) | hgap_evt;
      err_vgap  <= (err_vgap & ~clr_err) | vgap_evt;
      err_dim   <= (err_dim  & ~clr_err) | dim_evt;
      err_proto <= (err_proto & {5{~clr_err}}) | proto_evt;
    end
  end

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_line && !s_valid |=> in_line);

  // R11
  meas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ve_q |=> $stable(meas_width) && $stable(meas_height) &&
              $stable(meas_hblank) && $stable(meas_vblank));

  // R5
  hgap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hgap_evt |=> err_hgap);

  // R7
  vgap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vgap_evt |=> err_vgap);

  // R10
  dim_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |=> !err_dim);

  // R12
  hgap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_hgap && !clr_err |=> err_hgap);

  // R12
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err && !hgap_evt && !vgap_evt && !dim_evt && (proto_evt == 5'd0)
    |=> !err_hgap && !err_vgap && !err_dim && (err_proto == 5'd0));
endmodule

// File: tb/vid_timing_checker_tb_top.sv
module vid_timing_checker_tb_top;
  localparam int DIM_W = 12;
  localparam int KW_W  = 5;
  localparam int DMAX  = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_err = 1'b0, pad_en = 1'b1;
  logic [KW_W-1:0] kern_w = 5'd3, kern_h = 5'd3;
  logic s_valid = 1'b0, s_hstart = 1'b0, s_hend = 1'b0, s_vstart = 1'b0, s_vend = 1'b0;
  logic [DIM_W-1:0] meas_width, meas_height, meas_hblank, meas_vblank;
  logic err_hgap, err_vgap, err_dim;
  logic [4:0] err_proto;

  always #4 clk = ~clk;

  vid_timing_checker #(.DIM_W(DIM_W), .KW_W(KW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .pad_en(pad_en),
    .kern_w(kern_w), .kern_h(kern_h), .s_valid(s_valid), .s_hstart(s_hstart),
    .s_hend(s_hend), .s_vstart(s_vstart), .s_vend(s_vend),
    .meas_width(meas_width), .meas_height(meas_height), .meas_hblank(meas_hblank),
    .meas_vblank(meas_vblank), .err_hgap(err_hgap), .err_vgap(err_vgap),
    .err_proto(err_proto), .err_dim(err_dim));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference model: time stamps of the last markers, integers only
  int cyc = 0;
  bit m_line, m_frame, m_he_seen, m_hs_seen, m_vb_run, m_ref_ok;
  int m_pix, m_lastw, m_lines, m_min, m_per, m_he_t, m_hs_t, m_ve_t, m_pend, m_ref_w, m_ref_h;
  int e_w, e_h, e_hb, e_vb, e_proto;
  bit e_hg, e_vg, e_dim;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_line = 0; m_frame = 0; m_he_seen = 0; m_hs_seen = 0; m_vb_run = 0;
      m_ref_ok = 0; m_pix = 0; m_lastw = 0; m_lines = 0; m_min = DMAX; m_per = 0;
      m_he_t = 0; m_hs_t = 0; m_ve_t = 0; m_pend = 0; m_ref_w = 0; m_ref_h = 0;
      e_w = 0; e_h = 0; e_hb = 0; e_vb = 0; e_proto = 0; e_hg = 0; e_vg = 0; e_dim = 0;
    end else begin
      bit hs, he, vs, ve, old_line, old_frame, ev_h, ev_v, ev_d;
      int pe, thr, g, d, vl;
      cyc++;
      hs = s_valid & s_hstart; he = s_valid & s_hend;
      vs = s_valid & s_vstart; ve = s_valid & s_vend;
      old_line = m_line; old_frame = m_frame;
      ev_h = 0; ev_v = 0; ev_d = 0; pe = 0;
      thr = pad_en ? 2 * int'(kern_w) : 12;
      if (s_valid && !old_line && !hs) pe |= 16;
      if (vs) begin
        if (old_frame) pe |= 4;
        if (m_vb_run) begin
          d = cyc - m_ve_t;
          vl = (m_per == 0) ? 0 : d / m_per;
          if (vl > DMAX) vl = DMAX;
          m_pend = vl;
          if (vl < int'(kern_h)) ev_v = 1;
        end
        m_vb_run = 0; m_frame = 1; m_lines = 0; m_min = DMAX;
        m_he_seen = 0; m_hs_seen = 0;
      end
      if (hs) begin
        if (old_line) pe |= 1;
        if (m_he_seen) begin
          g = cyc - m_he_t - 1;
          if (g > DMAX) g = DMAX;
          if (g < thr) ev_h = 1;
          if (g < m_min) m_min = g;
        end
        if (m_hs_seen) m_per = cyc - m_hs_t;
        m_hs_t = cyc; m_hs_seen = 1; m_line = 1; m_pix = 1;
      end else if (old_line && s_valid) m_pix++;
      if (he) begin
        if (!old_line && !hs) pe |= 2;
        m_lastw = m_pix; m_lines++; m_line = 0; m_he_t = cyc; m_he_seen = 1;
      end
      if (ve) begin
        if ((!old_frame && !vs) || !he) pe |= 8;
        if (m_ref_ok && (m_lastw != m_ref_w || m_lines != m_ref_h)) ev_d = 1;
        e_w = m_lastw; e_h = m_lines; e_hb = m_min; e_vb = m_pend;
        m_ref_w = m_lastw; m_ref_h = m_lines; m_ref_ok = 1;
        m_frame = 0; m_vb_run = 1; m_ve_t = cyc;
      end
      if (clr_err) begin e_hg = 0; e_vg = 0; e_dim = 0; e_proto = 0; end
      e_hg |= ev_h; e_vg |= ev_v; e_dim |= ev_d; e_proto |= pe;
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R11", "meas_width",  int'(meas_width),  e_w);
      chk("R3 R11", "meas_height", int'(meas_height), e_h);
      chk("R4 R11", "meas_hblank", int'(meas_hblank), e_hb);
      chk("R6 R11", "meas_vblank", int'(meas_vblank), e_vb);
      chk("R5 R12", "err_hgap",    int'(err_hgap),    int'(e_hg));
      chk("R7 R12", "err_vgap",    int'(err_vgap),    int'(e_vg));
      chk("R8 R9 R12", "err_proto", int'(err_proto),  e_proto);
      chk("R10 R12", "err_dim",    int'(err_dim),     int'(e_dim));
    end
  end

  task automatic drv(input bit v, input bit hs, input bit he, input bit vs, input bit ve,
                     input bit c = 1'b0);
    s_valid = v; s_hstart = hs; s_hend = he; s_vstart = vs; s_vend = ve; clr_err = c;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit c = 1'b0);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, c && i == 0);
  endtask

  task automatic send_line(input int w, input int hole, input bit first, input bit last);
    for (int i = 0; i < w; i++) begin
      if (i == hole) idle(2);
      drv(1, i == 0, i == w - 1, first && i == 0, last && i == w - 1);
    end
  endtask

  // vl blank lines follow; idle sized as gap plus vl whole line periods
  task automatic frame(input int w, input int h, input int hb, input int vl, input int hole = -1);
    int p;
    p = w + hb + ((hole > 0) ? 2 : 0);
    for (int l = 0; l < h; l++) begin
      send_line(w, hole, l == 0, l == h - 1);
      if (l < h - 1) idle(hb);
    end
    idle(hb + vl * p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset meas", int'(meas_width | meas_height | meas_hblank | meas_vblank), 0);
    chk("R1", "reset errs", int'({err_hgap, err_vgap, err_dim, err_proto}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 markers without valid ignored
    s_hstart = 1; s_vstart = 1; @(negedge clk); s_hstart = 0; s_vstart = 0;
    idle(4);
    // clean frames, pad on: threshold 6, kh 3
    frame(8, 4, 8, 3);
    frame(8, 4, 8, 3);
    frame(8, 4, 8, 3);
    // R5 short line gap with padding
    frame(8, 4, 3, 3);
    idle(2, 1'b1);
    // R5 padding off: threshold 12
    pad_en = 1'b0;
    frame(8, 4, 11, 3);
    idle(2, 1'b1);
    frame(8, 4, 12, 3);
    // R7 vertical blanking one line short, then exact
    frame(8, 4, 12, 2);
    frame(8, 4, 12, 3);
    idle(2, 1'b1);
    // R10 size changes
    frame(6, 4, 12, 3);
    frame(6, 3, 12, 4);
    // R2 valid holes inside lines
    frame(6, 3, 12, 3, 2);
    frame(6, 3, 12, 3, 3);
    idle(2, 1'b1);
    // R8 R9 marker faults
    drv(1, 1, 0, 1, 0);
    drv(1, 0, 0, 0, 0);
    drv(1, 1, 0, 0, 0);
    drv(1, 0, 1, 0, 0);
    idle(12);
    drv(1, 0, 1, 0, 0);
    idle(3);
    drv(1, 0, 0, 0, 0);
    idle(12);
    drv(1, 1, 0, 0, 0);
    drv(1, 0, 0, 0, 1);
    drv(1, 0, 1, 0, 0);
    idle(30);
    drv(1, 0, 1, 0, 1);
    idle(30);
    drv(1, 1, 0, 1, 0);
    drv(1, 0, 1, 0, 0);
    idle(12);
    drv(1, 1, 0, 1, 0);
    drv(1, 0, 1, 0, 1);
    idle(60);
    idle(2, 1'b1);
    // R12 clear in the same cycle as a new line-gap fault
    pad_en = 1'b1; kern_w = 5'd4;
    drv(1, 1, 0, 1, 0);
    drv(1, 0, 1, 0, 0);
    idle(2);
    drv(1, 1, 0, 0, 0, 1'b1);
    drv(1, 0, 1, 0, 1);
    idle(40);
    frame(8, 2, 8, 3);
    frame(8, 2, 8, 3);
    idle(5);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule